// File: doc/BRIEF.md
# SPI EEPROM Command Sequencer

This block sits between a host and a byte-level SPI shifter. It turns host read and write requests into ordered EEPROM command frames and keeps the spacing that the memory needs between them. A write request first produces a one-byte frame that unlocks writing. After a fixed pause, the program frame follows, and the block then stays busy while the memory commits the bytes internally. A read request produces a single frame and no unlock frame. After a read, a second timer holds back any following write-side frame. Two further request codes reach the status register.

Each byte goes to the shifter with a one-cycle start pulse. The shifter answers with a one-cycle done pulse once it has finished all eight bit periods, including the low phase of the final clock, and returns the byte it received. Chip select belongs to the sequencer. It is low only while a frame is in progress and goes high on the edge that takes in the done pulse of the last byte. Every idle gap is a cycle count derived from `CLK_HZ` and a duration in microseconds.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `busy` is 0, `req_ready` is 1, and `spi_start`, `done`, `rd_valid` are 0.
- R2: A data write (`req_op`=01) produces an unlock frame holding only byte 0x06. A later frame then holds 0x02, address bits 15:8, address bits 7:0 and `req_len`+1 host data bytes. A frame whose first byte is 0x02 or 0x01 is always preceded by a frame whose first byte is 0x06.
- R3: Between the end of the unlock frame and the start of its write frame, `spi_cs_n` stays high for exactly CLK_HZ/1e6*WREN_GAP_US cycles.
- R4: After a write frame ends, chip select stays high and `req_ready` stays low for CLK_HZ/1e6*WRITE_CYC_US cycles.
- R5: A data read (`req_op`=00) produces one frame: 0x03, address high byte, address low byte, then `req_len`+1 bytes of 0x00. No unlock frame is sent. Each received byte appears on `rd_data` with a one-cycle `rd_valid`, in the cycle after the matching `spi_done`.
- R6: A write-side frame that follows a read sees `spi_cs_n` high for at least CLK_HZ/1e6*READ_GAP_US cycles after the read frame ends. This is exact when the write is already pending. A read that follows a read is not delayed: chip select is high for one cycle between the two frames.
- R7: `spi_start` occurs only while `spi_cs_n` is low. `spi_cs_n` rises only in the cycle after a `spi_done` and never while a byte is in flight. `spi_cs_n` is high in every gap state.
- R8: A status read (`req_op`=10) is one frame, 0x05 then one 0x00 byte, returned on `rd_data`, with no unlock frame. A status write (`req_op`=11) behaves like a data write with frame 0x01 followed by one host byte.
- R9: A request made while `busy` is held off with `req_ready` low and is served later. A write data byte is taken only on `wr_valid` and `wr_ready` together. While no byte is offered, the frame stalls with chip select low.
- R10: `done` pulses for one cycle with `busy` low. For a read it comes in the cycle chip select rises. For a write it comes at the end of the program wait, WRITE_CYC cycles after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 00 read, 01 write, 10 status read, 11 status write |
| req_addr | input | 16 | Memory address |
| req_len | input | LEN_W | Data byte count minus one |
| wr_data | input | 8 | Host byte to program |
| wr_valid | input | 1 | Host byte present |
| wr_ready | output | 1 | Sequencer takes the host byte |
| rd_data | output | 8 | Byte read from memory |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| busy | output | 1 | Transaction or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_start | output | 1 | Start one byte on the shifter |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Shifter finished the byte |
| spi_rx | input | 8 | Byte shifted in |

## Verification
The bench runs requests back to back so that every kind of gap appears: write after reset, read after write, read after read, status write after read, a data write whose single byte arrives late, and a read after that write. Read-then-read tells the read-only path from the write-side path, because only the second is held back by the read gap. Read-then-status-write shows that the read gap falls before the unlock frame and that the unlock-to-program gap follows it. The late-data write shows that a missing byte stalls the frame without shifting any gap.

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int WREN_GAP_US  = 10,
  parameter int READ_GAP_US  = 400,
  parameter int WRITE_CYC_US = 5000,
  parameter int LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_start,
  output logic [7:0]       spi_tx,
  input  logic             spi_done,
  input  logic [7:0]       spi_rx
);

  localparam int CYC_US   = CLK_HZ / 1_000_000;
  localparam int WREN_RAW = CYC_US * WREN_GAP_US;
  localparam int RD_RAW   = CYC_US * READ_GAP_US;
  localparam int WC_RAW   = CYC_US * WRITE_CYC_US;
  localparam int WREN_CYC = (WREN_RAW > 0) ? WREN_RAW : 1;
  localparam int RD_CYC   = (RD_RAW > 0) ? RD_RAW : 1;
  localparam int WC_CYC   = (WC_RAW > 0) ? WC_RAW : 1;
  localparam int GAP_MAX  = (WC_CYC > RD_CYC) ? ((WC_CYC > WREN_CYC) ? WC_CYC : WREN_CYC)
                                               : ((RD_CYC > WREN_CYC) ? RD_CYC : WREN_CYC);
  localparam int CNT_W    = $clog2(GAP_MAX + 1);
  localparam int IDX_W    = LEN_W + 2;

  typedef enum logic [2:0] {S_IDLE, S_WAIT_RD, S_WREN, S_WREN_GAP, S_MAIN, S_WR_CYC} state_t;

  state_t           state;
  logic [1:0]       op;
  logic [15:0]      addr;
  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] idx;
  logic             inflight;
  logic [CNT_W-1:0] gap_cnt;
  logic [CNT_W-1:0] rd_gap;

  logic             is_wr, is_stat, in_frame, data_phase, can_go, issue, frame_end;
  logic [IDX_W-1:0] hdr, last_idx;
  logic [7:0]       opcode, tx_next;

  assign is_wr      = op[0];
  assign is_stat    = op[1];
  assign hdr        = is_stat ? IDX_W'(1) : IDX_W'(3);
  assign last_idx   = is_stat ? IDX_W'(1) : IDX_W'(3) + IDX_W'(len);
  assign in_frame   = (state == S_WREN) || (state == S_MAIN);
  assign data_phase = (state == S_MAIN) && (idx >= hdr);
  assign can_go     = in_frame && !inflight;
  assign wr_ready   = can_go && data_phase && is_wr;
  assign issue      = can_go && (!(data_phase && is_wr) || wr_valid);
  assign frame_end  = in_frame && inflight && spi_done && ((state == S_WREN) || (idx == last_idx));
  assign busy       = (state != S_IDLE);
  assign req_ready  = (state == S_IDLE);

  always_comb begin
    case (op)
      2'b00:   opcode = 8'h03;
      2'b01:   opcode = 8'h02;
      2'b10:   opcode = 8'h05;
      default: opcode = 8'h01;
    endcase
    if (state == S_WREN)     tx_next = 8'h06;
    else if (idx == '0)      tx_next = opcode;
    else if (!data_phase)    tx_next = (idx == IDX_W'(1)) ? addr[15:8] : addr[7:0];
    else if (is_wr)          tx_next = wr_data;
    else                     tx_next = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op        <= '0;
      addr      <= '0;
      len       <= '0;
      idx       <= '0;
      inflight  <= 1'b0;
      gap_cnt   <= '0;
      spi_cs_n  <= 1'b1;
      spi_start <= 1'b0;
      spi_tx    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      spi_start <= 1'b0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
      if (issue) begin
        spi_start <= 1'b1;
        spi_tx    <= tx_next;
        inflight  <= 1'b1;
      end
      if (in_frame && inflight && spi_done) begin
        inflight <= 1'b0;
        idx      <= idx + 1'b1;
        if (data_phase && !is_wr) begin
          rd_valid <= 1'b1;
          rd_data  <= spi_rx;
        end
      end
      case (state)
        S_IDLE: if (req_valid) begin
          op   <= req_op;
          addr <= req_addr;
          len  <= req_len;
          idx  <= '0;
          if (req_op[0]) begin
            if (rd_gap == '0) begin
              state    <= S_WREN;
              spi_cs_n <= 1'b0;
            end else begin
              state <= S_WAIT_RD;
            end
          end else begin
            state    <= S_MAIN;
            spi_cs_n <= 1'b0;
          end
        end
        S_WAIT_RD: if (rd_gap == '0) begin
          state    <= S_WREN;
          spi_cs_n <= 1'b0;
        end
        S_WREN: if (frame_end) begin
          spi_cs_n <= 1'b1;
          idx      <= '0;
          gap_cnt  <= CNT_W'(WREN_CYC - 1);
          state    <= S_WREN_GAP;
        end
        S_WREN_GAP: begin
          if (gap_cnt == '0) begin
            state    <= S_MAIN;
            spi_cs_n <= 1'b0;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        S_MAIN: if (frame_end) begin
          spi_cs_n <= 1'b1;
          if (is_wr) begin
            gap_cnt <= CNT_W'(WC_CYC - 1);
            state   <= S_WR_CYC;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_WR_CYC: begin
          if (gap_cnt == '0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     rd_gap <= '0;
    else if ((state == S_MAIN) && frame_end && !is_wr) rd_gap <= CNT_W'(RD_CYC - 1);
    else if (rd_gap != '0)                          rd_gap <= rd_gap - 1'b1;
  end

  logic       chk_new;
  logic [7:0] chk_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_new  <= 1'b1;
      chk_last <= '0;
    end else if (spi_cs_n) begin
      chk_new <= 1'b1;
    end else if (spi_start) begin
      chk_new <= 1'b0;
      if (chk_new) chk_last <= spi_tx;
    end
  end

  AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && chk_new && (spi_tx == 8'h02 || spi_tx == 8'h01)) |-> (chk_last == 8'h06)); // R2
  AST_GAP_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WREN_GAP || state == S_WR_CYC || state == S_WAIT_RD) |-> spi_cs_n); // R3
  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n); // R7
  AST_CS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_done)); // R7
  AST_RD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(spi_done)); // R5
  AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $stable(spi_cs_n) || $rose(spi_cs_n))); // R10

endmodule

// File: tb/spi_eeprom_seq_test.sv
`timescale 1ns/1ps
module spi_eeprom_seq_test;
  localparam int CLK_HZ = 2_000_000;
  localparam int G  = CLK_HZ / 1_000_000 * 10;
  localparam int RG = CLK_HZ / 1_000_000 * 400;
  localparam int WC = CLK_HZ / 1_000_000 * 100;
  localparam int SHIFT = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_len = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, busy, done, spi_cs_n, spi_start;
  logic [7:0] spi_tx;
  logic spi_done = 0;
  logic [7:0] spi_rx = 0;

  always #4 clk = ~clk;

  spi_eeprom_seq #(.CLK_HZ(CLK_HZ), .WREN_GAP_US(10), .READ_GAP_US(400), .WRITE_CYC_US(100), .LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done), .spi_cs_n(spi_cs_n),
    .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx));

  int total = 0, bad = 0;
  logic [8:0] exp_q[$];
  int exp_len[$], exp_gap[$], exp_done[$];
  logic [7:0] rd_q[$], wdat_q[$];
  int prev_kind = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // host byte feeder
  bit take = 0;
  initial forever begin
    @(negedge clk);
    if (take && wdat_q.size() > 0) void'(wdat_q.pop_front());
    wr_valid = (wdat_q.size() > 0);
    wr_data = wr_valid ? wdat_q[0] : 8'h00;
    #1 take = wr_valid && wr_ready;
  end

  // shifter model and scoreboard monitor
  int sh_cnt = 0, rx_ctr = 0, frm_bytes = 0, hi_cnt = 0;
  bit sh_busy = 0, cur_flag = 0, prev_cs = 1;
  always @(negedge clk) if (rst_n) begin
    spi_done = 0;
    if (rd_valid) begin
      if (rd_q.size() == 0) chk(0, "R5 unexpected rd_valid", rd_data, 0);
      else begin
        logic [7:0] e;
        e = rd_q.pop_front();
        chk(rd_data == e, "R5 read byte", rd_data, e);
      end
    end
    if (sh_busy) begin
      sh_cnt--;
      if (sh_cnt == 0) begin
        sh_busy = 0;
        spi_done = 1;
        spi_rx = 8'h5A + 8'(rx_ctr);
        rx_ctr++;
        if (cur_flag) rd_q.push_back(spi_rx);
      end
    end
    if (spi_start) begin
      chk(!sh_busy, "R7 start while byte in flight", 1, 0);
      if (exp_q.size() == 0) chk(0, "R2 unexpected byte", spi_tx, 0);
      else begin
        logic [8:0] it;
        it = exp_q.pop_front();
        chk(spi_tx == it[7:0], "R2 frame byte", spi_tx, it[7:0]);
        cur_flag = it[8];
      end
      frm_bytes++;
      sh_busy = 1;
      sh_cnt = SHIFT;
    end
    if (spi_cs_n) begin
      if (!prev_cs) begin
        int el;
        el = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
        chk(frm_bytes == el, "R7 frame length", frm_bytes, el);
        chk(!sh_busy, "R7 cs rose with byte in flight", 1, 0);
        frm_bytes = 0;
        hi_cnt = 0;
      end
      hi_cnt++;
    end else if (prev_cs) begin
      int eg;
      eg = (exp_gap.size() > 0) ? exp_gap.pop_front() : -2;
      if (eg != -1) chk(hi_cnt == eg, "R3 R6 cs high gap", hi_cnt, eg);
    end
    if (done) begin
      int ed;
      ed = (exp_done.size() > 0) ? exp_done.pop_front() : -2;
      chk(hi_cnt == ed && !busy, "R4 R10 done timing", hi_cnt, ed);
    end
    prev_cs = spi_cs_n;
  end

  task automatic txn(input logic [1:0] op, input logic [15:0] a, input logic [7:0] n, input bit late);
    bit wr = op[0], st = op[1];
    int g, nb;
    logic [7:0] opc, d;
    logic [7:0] late_q[$];
    g = (prev_kind == 0) ? -1 : (prev_kind == 2) ? WC + 1 : (wr ? RG : 1);
    opc = (op == 2'b00) ? 8'h03 : (op == 2'b01) ? 8'h02 : (op == 2'b10) ? 8'h05 : 8'h01;
    nb = st ? 1 : int'(n) + 1;
    if (wr) begin
      exp_len.push_back(1);
      exp_gap.push_back(g);
      exp_q.push_back({1'b0, 8'h06});
      g = G;
    end
    exp_gap.push_back(g);
    exp_len.push_back((st ? 1 : 3) + nb);
    exp_q.push_back({1'b0, opc});
    if (!st) begin
      exp_q.push_back({1'b0, a[15:8]});
      exp_q.push_back({1'b0, a[7:0]});
    end
    for (int k = 0; k < nb; k++) begin
      d = wr ? (8'hC0 + 8'(k) + {4'h0, a[3:0]}) : 8'h00;
      exp_q.push_back({!wr, d});
      if (wr) begin
        if (late) late_q.push_back(d);
        else wdat_q.push_back(d);
      end
    end
    if (late) fork
      begin
        repeat (G + 40) @(negedge clk);
        foreach (late_q[i]) wdat_q.push_back(late_q[i]);
      end
    join_none
    exp_done.push_back(wr ? WC + 1 : 1);
    prev_kind = wr ? 2 : 1;
    req_op = op; req_addr = a; req_len = n; req_valid = 1;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  bit wd_hit = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs_n && !busy && req_ready && !spi_start && !done && !rd_valid, "R1 reset state",
        {spi_cs_n, busy, req_ready, spi_start, done, rd_valid}, 6'b101000);
    fork
      begin
        txn(2'b01, 16'h1234, 8'd2, 0);            // R2 R3 R4 data write
        repeat (15) @(negedge clk);
        chk(!req_ready && busy, "R9 held off while busy", req_ready, 0);
        txn(2'b00, 16'hABCD, 8'd3, 0);            // R5 read after write, held (R9)
        txn(2'b10, 16'h0000, 8'd0, 0);            // R8 status read, read after read (R6)
        txn(2'b11, 16'h0009, 8'd0, 0);            // R8 status write after read (R6)
        txn(2'b01, 16'h0F07, 8'd0, 1);            // R9 late data byte stalls frame
        txn(2'b00, 16'h0042, 8'd1, 0);            // R5 read after write
        while (busy || exp_done.size() > 0) @(negedge clk);
        repeat (5) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) chk(0, "R10 watchdog expired", 0, 1);
    chk(exp_q.size() == 0 && exp_len.size() == 0 && exp_gap.size() == 0 && rd_q.size() == 0,
        "R2 R5 scoreboard drained", exp_q.size() + exp_len.size() + rd_q.size(), 0);
    chk(spi_cs_n && !busy, "R7 idle at end with cs high", spi_cs_n, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule